// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block sits between a byte-wide host bus and the counting cores of a multi-channel 16-bit interval timer. The host reaches it through a 2-bit address: three addresses lead to the per-channel count ports and the fourth is a write-only command port. Commands program a channel's byte access order, counting mode and decimal flag. They can also freeze a channel's live count, or freeze the count and/or a status byte of several channels in one write. Count ports move the 16-bit values one byte at a time, in the order the channel was programmed for.

Each channel core supplies its live count and its output pin level. In return the block gives each core a one-cycle load strobe with a 16-bit reload value. How the cores count, and how gating works, are outside this block. A small down-counter is included only so the testbench can close the loop. Reads follow a fixed precedence: a frozen status byte first, then frozen count bytes, then the live count.

Top module: `tmr_regif_top`

## Requirements
- R1: Only addr[1:0] is decoded. Addresses 0, 1 and 2 are the count ports of channels 0, 1 and 2, and address 3 is the command port. A read at address 3 returns 8'h00, and rd_data is 8'h00 whenever rd_en is low.
- R2: A command byte carries the channel select in [7:6], the access order in [5:4] (1 = low byte only, 2 = high byte only, 3 = low then high), the counting mode in [3:1] and the decimal flag in [0]. A nonzero access order stores all three settings in the selected channel and restarts both that channel's read and write byte sequencers at the low byte.
- R3: A command with access order 0 freezes the selected channel's live count and leaves that channel's access order, counting mode and decimal flag unchanged.
- R4: A command with select 3 is a multi-channel capture. Bits 1, 2 and 3 pick channels 0, 1 and 2. Bit 5 at 0 freezes the count and bit 4 at 0 freezes the status of every picked channel.
- R5: A status byte holds the output pin level in bit 7, 0 in bit 6, the access order in [5:4], the counting mode in [3:1] and the decimal flag in bit 0, all taken at the moment of capture.
- R6: A count or status capture aimed at a channel that still holds an unread capture of the same kind is ignored. The first captured value is the one that is read.
- R7: A count-port read returns the frozen status byte if there is one and clears it. Otherwise it returns the frozen count bytes in the access order in force at capture (low then high for order 3), and the capture clears after its last byte. Only with nothing frozen does it return the live count.
- R8: In access order 3, the first byte written to a count port is held. The second byte forms {second, first}, and load_strobe for that channel and load_value appear in the cycle after that write. The sequencer then expects a low byte again.
- R9: In access order 1, a written byte loads as {8'h00, byte}. In access order 2 it loads as {byte, 8'h00}. Either load happens in the cycle after the write.
- R10: Live-count reads return the low byte in order 1 and the high byte in order 2. In order 3 they alternate low, high, low, and this alternation is independent of the write sequencer.
- R11: After reset every channel has access order 1, counting mode 0 and decimal flag 0, with no captures pending, both sequencers at the low byte and no load strobe.
- R12: A reload value of zero is passed on as 16'h0000 and means a full 65536-step period: the included counter steps from 0 to 16'hFFFF.
- R13: load_strobe has at most one bit set, and a load strobe lasts one cycle for each count-port write that completes a value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Host address: count ports 0..2, command port 3 |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Host read byte, valid during rd_en |
| live_count | input | NUM_CH*16 | Live count of each channel core, channel 0 in the low bits |
| out_state | input | NUM_CH | Output pin level of each channel core |
| load_strobe | output | NUM_CH | One-cycle reload request per channel |
| load_value | output | NUM_CH*16 | Reload value per channel, valid with its strobe |

## Verification
A sweep covers every channel under every access order, each with its own counting mode, decimal flag and arithmetically derived count. In each case the load values, the live-byte order and the captured status byte are compared against what the access order predicts, which separates low-only, high-only and paired handling. Directed sequences then let the live count move between a capture and its read, so a held capture can be told apart from a live read, a repeated capture or a lost one. They also stack status and count captures to show the read precedence, and interleave reads with half-finished writes to show the two sequencers are separate. A zero reload followed by one counting step shows the full-range wrap.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;

    localparam int BYTE_W   = 8;
    localparam int COUNT_W  = 2 * BYTE_W;
    localparam int CHANNELS = 3;

    localparam logic [1:0] CMD_ADDR   = 2'd3;
    localparam logic [1:0] SEL_MULTI  = 2'd3;
    localparam int         MULTI_NOCNT_BIT = 5;
    localparam int         MULTI_NOSTS_BIT = 4;

    typedef enum logic [1:0] {
        ACC_FREEZE = 2'd0,
        ACC_LOW    = 2'd1,
        ACC_HIGH   = 2'd2,
        ACC_PAIR   = 2'd3
    } acc_e;

    typedef struct packed {
        logic [1:0] sel;
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } cmd_word_t;

    typedef struct packed {
        logic setup;
        logic cnt_cap;
        logic sts_cap;
        logic wr;
        logic rd;
    } chan_cmd_t;

    typedef struct packed {
        acc_e               acc;
        logic [2:0]         mode;
        logic               bcd;
        logic               wr_hi;
        logic               rd_hi;
        logic [BYTE_W-1:0]  hold;
        logic               cap_vld;
        logic               cap_hi;
        logic               cap_two;
        logic [COUNT_W-1:0] cap_val;
        logic               sts_vld;
        logic [BYTE_W-1:0]  sts;
    } chan_state_t;

    function automatic chan_state_t chan_reset();
        chan_state_t s;
        s         = '0;
        s.acc     = ACC_LOW;
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] lo_byte(input logic [COUNT_W-1:0] v);
        return v[BYTE_W-1:0];
    endfunction

    function automatic logic [BYTE_W-1:0] hi_byte(input logic [COUNT_W-1:0] v);
        return v[COUNT_W-1:BYTE_W];
    endfunction

    function automatic logic [BYTE_W-1:0] make_status(input logic pin, input acc_e acc,
                                                      input logic [2:0] mode, input logic bcd);
        return {pin, 1'b0, acc, mode, bcd};
    endfunction

endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
    import tmr_regif_pkg::*;
#(
    parameter int NUM_CH = CHANNELS
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wr_data,
    output cmd_word_t         cw,
    output chan_cmd_t         cmd [NUM_CH]
);

    logic is_cmd;
    logic is_multi;

    assign cw       = cmd_word_t'(wr_data);
    assign is_cmd   = wr_en && (addr == CMD_ADDR);
    assign is_multi = is_cmd && (cw.sel == SEL_MULTI);

    // Multi-channel capture picks channel g with bit g+1; supports up to three channels.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic direct;
        logic picked;
        assign direct = is_cmd && (cw.sel == 2'(g));
        assign picked = is_multi && wr_data[g+1];

        assign cmd[g].setup   = direct && (cw.acc != ACC_FREEZE);
        assign cmd[g].cnt_cap = (direct && (cw.acc == ACC_FREEZE))
                              || (picked && !wr_data[MULTI_NOCNT_BIT]);
        assign cmd[g].sts_cap = picked && !wr_data[MULTI_NOSTS_BIT];
        assign cmd[g].wr      = wr_en && (addr == 2'(g));
        assign cmd[g].rd      = rd_en && (addr == 2'(g));
    end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_regif_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  chan_cmd_t          cmd,
    input  cmd_word_t          cw,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic [COUNT_W-1:0] live_count,
    input  logic               out_pin,
    output logic [BYTE_W-1:0]  rd_byte,
    output logic               load_stb,
    output logic [COUNT_W-1:0] load_val
);

    chan_state_t        st_q, st_d;
    logic               ld_d;
    logic [COUNT_W-1:0] ldv_d;

    // Byte presented to the host: status, then frozen count, then live count.
    always_comb begin
        if (st_q.sts_vld) begin
            rd_byte = st_q.sts;
        end else if (st_q.cap_vld) begin
            rd_byte = st_q.cap_hi ? hi_byte(st_q.cap_val) : lo_byte(st_q.cap_val);
        end else begin
            unique case (st_q.acc)
                ACC_HIGH: rd_byte = hi_byte(live_count);
                ACC_PAIR: rd_byte = st_q.rd_hi ? hi_byte(live_count) : lo_byte(live_count);
                default:  rd_byte = lo_byte(live_count);
            endcase
        end
    end

    always_comb begin
        st_d  = st_q;
        ld_d  = 1'b0;
        ldv_d = '0;

        if (cmd.rd) begin
            if (st_q.sts_vld) begin
                st_d.sts_vld = 1'b0;
            end else if (st_q.cap_vld) begin
                if (st_q.cap_two) begin
                    st_d.cap_two = 1'b0;
                    st_d.cap_hi  = 1'b1;
                end else begin
                    st_d.cap_vld = 1'b0;
                end
            end else if (st_q.acc == ACC_PAIR) begin
                st_d.rd_hi = !st_q.rd_hi;
            end
        end

        if (cmd.setup) begin
            st_d.acc   = cw.acc;
            st_d.mode  = cw.mode;
            st_d.bcd   = cw.bcd;
            st_d.wr_hi = 1'b0;
            st_d.rd_hi = 1'b0;
        end

        if (cmd.cnt_cap && !st_q.cap_vld) begin
            st_d.cap_vld = 1'b1;
            st_d.cap_val = live_count;
            st_d.cap_hi  = (st_q.acc == ACC_HIGH);
            st_d.cap_two = (st_q.acc == ACC_PAIR);
        end

        if (cmd.sts_cap && !st_q.sts_vld) begin
            st_d.sts_vld = 1'b1;
            st_d.sts     = make_status(out_pin, st_q.acc, st_q.mode, st_q.bcd);
        end

        if (cmd.wr) begin
            unique case (st_q.acc)
                ACC_HIGH: begin
                    ld_d  = 1'b1;
                    ldv_d = {wr_data, {BYTE_W{1'b0}}};
                end
                ACC_PAIR: begin
                    if (st_q.wr_hi) begin
                        ld_d       = 1'b1;
                        ldv_d      = {wr_data, st_q.hold};
                        st_d.wr_hi = 1'b0;
                    end else begin
                        st_d.hold  = wr_data;
                        st_d.wr_hi = 1'b1;
                    end
                end
                default: begin
                    ld_d  = 1'b1;
                    ldv_d = {{BYTE_W{1'b0}}, wr_data};
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= chan_reset();
            load_stb <= 1'b0;
            load_val <= '0;
        end else begin
            st_q     <= st_d;
            load_stb <= ld_d;
            load_val <= ldv_d;
        end
    end

endmodule

// File: rtl/tmr_demo_counter.sv
module tmr_demo_counter
    import tmr_regif_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [COUNT_W-1:0] load_val,
    input  logic               dec_en,
    output logic [COUNT_W-1:0] count,
    output logic               at_zero
);

    assign at_zero = (count == '0);

    // A reload of zero steps to all ones next: a full 2**COUNT_W period.
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec_en) begin
            count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/tmr_regif_top.sv
module tmr_regif_top
    import tmr_regif_pkg::*;
#(
    parameter int NUM_CH = CHANNELS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                addr,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [BYTE_W-1:0]         wr_data,
    output logic [BYTE_W-1:0]         rd_data,
    input  logic [NUM_CH*COUNT_W-1:0] live_count,
    input  logic [NUM_CH-1:0]         out_state,
    output logic [NUM_CH-1:0]         load_strobe,
    output logic [NUM_CH*COUNT_W-1:0] load_value
);

    cmd_word_t         cw;
    chan_cmd_t         cmd      [NUM_CH];
    logic [BYTE_W-1:0] chan_byte [NUM_CH];

    tmr_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .cw      (cw),
        .cmd     (cmd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        tmr_chan_regs u_regs (
            .clk        (clk),
            .rst        (rst),
            .cmd        (cmd[g]),
            .cw         (cw),
            .wr_data    (wr_data),
            .live_count (live_count[g*COUNT_W +: COUNT_W]),
            .out_pin    (out_state[g]),
            .rd_byte    (chan_byte[g]),
            .load_stb   (load_strobe[g]),
            .load_val   (load_value[g*COUNT_W +: COUNT_W])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_en && (addr != CMD_ADDR)) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == 2'(i)) rd_data = chan_byte[i];
            end
        end
    end

endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk
    import tmr_regif_pkg::*;
#(
    parameter int NUM_CH = CHANNELS
) (
    input logic                      clk,
    input logic                      rst,
    input logic [1:0]                addr,
    input logic                      wr_en,
    input logic                      rd_en,
    input logic [BYTE_W-1:0]         wr_data,
    input logic [BYTE_W-1:0]         rd_data,
    input logic [NUM_CH*COUNT_W-1:0] live_count,
    input logic [NUM_CH-1:0]         out_state,
    input logic [NUM_CH-1:0]         load_strobe,
    input logic [NUM_CH*COUNT_W-1:0] load_value
);

    AST_CMD_PORT_READ_BLANK: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == CMD_ADDR) |-> (rd_data == '0)); // R1

    AST_IDLE_READ_BLANK: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0)); // R1

    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_strobe)); // R13

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        AST_LOAD_FOLLOWS_PORT_WRITE: assert property (@(posedge clk) disable iff (rst)
            load_strobe[g] |-> $past(wr_en && addr == 2'(g))); // R8

        AST_LOAD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
            (load_strobe[g] && !(wr_en && addr == 2'(g))) |=> !load_strobe[g]); // R13

        AST_LOAD_CARRIES_LAST_BYTE: assert property (@(posedge clk) disable iff (rst)
            load_strobe[g] |->
                (load_value[g*COUNT_W +: BYTE_W] == $past(wr_data)) ||
                (load_value[g*COUNT_W+BYTE_W +: BYTE_W] == $past(wr_data))); // R9
    end

endmodule

bind tmr_regif_top tmr_regif_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/tmr_regif_top_bench.sv
`timescale 1ns/1ps
module tmr_regif_top_bench;
    import tmr_regif_pkg::*;

    localparam int NCH = 3;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [1:0]              addr = '0;
    logic                    wr_en = 1'b0;
    logic                    rd_en = 1'b0;
    logic [7:0]              wr_data = '0;
    logic [7:0]              rd_data;
    logic [NCH*16-1:0]       live_count;
    logic [NCH-1:0]          out_state;
    logic [NCH-1:0]          load_strobe;
    logic [NCH*16-1:0]       load_value;
    logic [NCH-1:0]          dec_en = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] exp_cnt [NCH];

    always #2 clk = ~clk;

    tmr_regif_top #(.NUM_CH(NCH)) u_tmr_regif_top (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .live_count(live_count),
        .out_state(out_state), .load_strobe(load_strobe), .load_value(load_value)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ctr
        tmr_demo_counter u_ctr (
            .clk(clk), .rst(rst), .load(load_strobe[g]),
            .load_val(load_value[g*16 +: 16]), .dec_en(dec_en[g]),
            .count(live_count[g*16 +: 16]), .at_zero(out_state[g])
        );
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] status_of(input logic pin, input logic [1:0] acc,
                                             input logic [2:0] mode, input logic bcd);
        return {pin, 1'b0, acc, mode, bcd};
    endfunction

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input int ch, input logic [7:0] exp, input string req);
        logic [7:0] d;
        do_rd(2'(ch), d);
        check(req, {8'h00, d}, {8'h00, exp});
    endtask

    // Count-port write; checks the strobe in the following cycle and waits for the counter to load.
    task automatic port_wr(input int ch, input logic [7:0] d, input bit ld,
                           input logic [15:0] expv, input string req);
        do_wr(2'(ch), d);
        check({req, " strobe"}, {13'h0, load_strobe}, ld ? 16'(1 << ch) : 16'h0);
        if (ld) begin
            check({req, " value"}, load_value[ch*16 +: 16], expv);
            exp_cnt[ch] = expv;
        end
        @(posedge clk); #1;
    endtask

    task automatic dec(input int ch, input int n);
        @(negedge clk);
        dec_en[ch] = 1'b1;
        repeat (n) @(posedge clk);
        #1 dec_en[ch] = 1'b0;
        exp_cnt[ch] = exp_cnt[ch] - 16'(n);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  cw;
        logic [7:0]  d;
        logic [15:0] v;
        logic [2:0]  md;
        logic        bc;

        for (int i = 0; i < NCH; i++) exp_cnt[i] = 16'h0000;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R11: reset state
        check("R11 no strobe after reset", {13'h0, load_strobe}, 16'h0);
        rd_chk(0, 8'h00, "R11 live low byte after reset");
        do_wr(2'd3, 8'hE2);
        rd_chk(0, status_of(1'b1, 2'd1, 3'd0, 1'b0), "R11 reset status");
        rd_chk(1, 8'h00, "R11 channel 1 live after reset");

        // R1: command port and idle reads
        rd_chk(3, 8'h00, "R1 read at command port");
        @(negedge clk); addr = 2'd0; #1;
        check("R1 idle rd_data", {8'h00, rd_data}, 16'h0000);

        // Sweep: every channel under every access order
        for (int ch = 0; ch < NCH; ch++) begin
            for (int a = 1; a < 4; a++) begin
                md = 3'((ch + a) % 6);
                bc = 1'((ch + a) & 1);
                cw = {2'(ch), 2'(a), md, bc};
                v  = 16'h2468 + 16'(ch) * 16'h1111 + 16'(a) * 16'h0123;
                do_wr(2'd3, cw);
                if (a == 1) begin
                    port_wr(ch, v[7:0], 1'b1, {8'h00, v[7:0]}, "R9 low-only load");
                    rd_chk(ch, exp_cnt[ch][7:0], "R10 low-only live read");
                    rd_chk(ch, exp_cnt[ch][7:0], "R10 low-only live read repeat");
                end else if (a == 2) begin
                    port_wr(ch, v[15:8], 1'b1, {v[15:8], 8'h00}, "R9 high-only load");
                    rd_chk(ch, exp_cnt[ch][15:8], "R10 high-only live read");
                    rd_chk(ch, exp_cnt[ch][15:8], "R10 high-only live read repeat");
                end else begin
                    port_wr(ch, v[7:0], 1'b0, 16'h0, "R8 first byte held");
                    port_wr(ch, v[15:8], 1'b1, v, "R8 pair load");
                    rd_chk(ch, exp_cnt[ch][7:0], "R10 pair live low");
                    rd_chk(ch, exp_cnt[ch][15:8], "R10 pair live high");
                    rd_chk(ch, exp_cnt[ch][7:0], "R10 pair live low again");
                end
                do_wr(2'd3, 8'hE0 | 8'(1 << (ch + 1)));
                rd_chk(ch, status_of(exp_cnt[ch] == 16'h0, 2'(a), md, bc), "R5 R2 status fields");
            end
        end

        // R3 and R6: single-channel freeze keeps settings and ignores a second request
        do_wr(2'd3, 8'h74);
        port_wr(1, 8'h34, 1'b0, 16'h0, "R8 hold");
        port_wr(1, 8'h12, 1'b1, 16'h1234, "R8 load 1234");
        do_wr(2'd3, 8'h4E);
        dec(1, 5);
        do_wr(2'd3, 8'h40);
        rd_chk(1, 8'h34, "R3 frozen low byte");
        rd_chk(1, 8'h12, "R6 frozen high byte keeps first capture");
        rd_chk(1, exp_cnt[1][7:0], "R7 live after frozen bytes");
        do_wr(2'd3, 8'hE4);
        rd_chk(1, status_of(1'b0, 2'd3, 3'd2, 1'b0), "R3 settings unchanged by freeze");

        // R4 and R6: multi-channel count capture protected against a second capture
        do_wr(2'd3, 8'hD4);
        dec(1, 3);
        do_wr(2'd3, 8'hD4);
        rd_chk(1, 8'h2F, "R6 multi capture low");
        rd_chk(1, 8'h12, "R6 multi capture high");

        // R7: status, then frozen count, then live; status capture protection
        do_wr(2'd3, 8'hB6);
        port_wr(2, 8'hCD, 1'b0, 16'h0, "R8 hold");
        port_wr(2, 8'hAB, 1'b1, 16'hABCD, "R8 load ABCD");
        do_wr(2'd3, 8'hC8);
        rd_chk(2, status_of(1'b0, 2'd3, 3'd3, 1'b0), "R7 status first");
        rd_chk(2, 8'hCD, "R7 frozen low second");
        rd_chk(2, 8'hAB, "R7 frozen high third");
        rd_chk(2, 8'hCD, "R7 live afterwards");
        do_wr(2'd3, 8'hE8);
        do_wr(2'd3, 8'hB2);
        do_wr(2'd3, 8'hE8);
        rd_chk(2, status_of(1'b0, 2'd3, 3'd3, 1'b0), "R6 first status kept");
        rd_chk(2, exp_cnt[2][7:0], "R7 live after status cleared");

        // R4: capture counts of all channels at once, each in its own order
        do_wr(2'd3, 8'h30);
        port_wr(0, 8'h11, 1'b0, 16'h0, "R8 hold");
        port_wr(0, 8'h22, 1'b1, 16'h2211, "R8 load 2211");
        do_wr(2'd3, 8'h50);
        port_wr(1, 8'h77, 1'b1, 16'h0077, "R9 load 0077");
        do_wr(2'd3, 8'hA0);
        port_wr(2, 8'h99, 1'b1, 16'h9900, "R9 load 9900");
        do_wr(2'd3, 8'hDE);
        dec(0, 2); dec(1, 2); dec(2, 2);
        rd_chk(0, 8'h11, "R4 channel 0 captured low");
        rd_chk(0, 8'h22, "R4 channel 0 captured high");
        rd_chk(1, 8'h77, "R4 channel 1 captured low only");
        rd_chk(1, 8'h75, "R4 channel 1 live after one byte");
        rd_chk(2, 8'h99, "R4 channel 2 captured high only");
        rd_chk(2, 8'h98, "R4 channel 2 live after one byte");

        // R12: zero reload gives a full-range period
        do_wr(2'd3, 8'h30);
        port_wr(0, 8'h00, 1'b0, 16'h0, "R8 hold");
        port_wr(0, 8'h00, 1'b1, 16'h0000, "R12 zero reload");
        do_wr(2'd3, 8'hE2);
        rd_chk(0, status_of(1'b1, 2'd3, 3'd0, 1'b0), "R12 pin at zero");
        dec(0, 1);
        rd_chk(0, 8'hFF, "R12 wrap low");
        rd_chk(0, 8'hFF, "R12 wrap high");
        do_wr(2'd3, 8'hE2);
        rd_chk(0, status_of(1'b0, 2'd3, 3'd0, 1'b0), "R12 pin after step");

        // R10: read alternation independent of the write sequencer
        do_wr(2'd3, 8'h30);
        port_wr(0, 8'h56, 1'b0, 16'h0, "R10 write low held");
        rd_chk(0, 8'hFF, "R10 live low during half write");
        port_wr(0, 8'h78, 1'b1, 16'h7856, "R10 write completes");
        rd_chk(0, 8'h78, "R10 read continues with high");
        rd_chk(0, 8'h56, "R10 read back to low");

        // R2: a command restarts the write sequencer
        do_wr(2'd3, 8'h30);
        port_wr(0, 8'hAA, 1'b0, 16'h0, "R2 stale half write");
        do_wr(2'd3, 8'h30);
        port_wr(0, 8'h01, 1'b0, 16'h0, "R2 restart expects low");
        port_wr(0, 8'h02, 1'b1, 16'h0201, "R2 restart pair load");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule